// File: doc/BRIEF.md
# Complementary PWM Deadband Generator

This block turns a single raw pulse-width-modulated level into two drive signals for a half-bridge: a high-side drive that follows the raw level and a low-side drive that follows its inverse. When the pair is enabled, a programmable gap of system clocks is placed in front of every turn-on. During that gap both drives stay low, so the two transistors of a leg are never on together. The gap is counted in undivided system clocks and is taken out of the active time of the drive that is turning on. The period of the raw signal is therefore unchanged.

A controller places the block between its PWM modulator and the output pins. It sets an 8-bit gap length on `dead_cycles` and chooses complementary operation with `pair_en`. With `pair_en` low, the drives simply track the raw level and its inverse, with no gap. A new gap length is captured when a gap starts. Changing it has no effect on a gap already running.

The controller is a five-state machine. `ST_OFF` is the reset state, with both drives low. `ST_LO_ON` and `ST_HI_ON` each have one drive asserted. `ST_GAP_HI` and `ST_GAP_LO` have both drives low while the gap counter runs toward the named side.

The transitions are:
- **Start:** `ST_OFF` goes to the gap toward the sampled raw level.
- **Edge:** `ST_LO_ON` on a high raw goes to `ST_GAP_HI`, or straight to `ST_HI_ON` when the gap is zero. `ST_HI_ON` on a low raw behaves the same way toward the low side.
- **Expire:** a gap state whose counter reaches its last cycle enters its on state.
- **Reverse:** a gap state that sees the raw level flip restarts the counter toward the other side.
- **Bypass:** any state goes to `ST_HI_ON` or `ST_LO_ON` from the raw level whenever `pair_en` is low.

Top module: `cpwm_deadtime`

## Requirements
- R1: During reset (active-low `rst_n`, asynchronous) both drives are 0 and the gap counter is cleared. The first clock edge after release starts a gap of `dead_cycles` clocks toward the side selected by `pwm_raw`.
- R2: In pair mode, when `pwm_raw` is sampled 1 while `drive_lo` is on, `drive_lo` is 0 after that same edge. `drive_hi` becomes 1 after the edge that is D clocks later, where D is the value of `dead_cycles` at the first edge.
- R3: In pair mode, when `pwm_raw` is sampled 0 while `drive_hi` is on, `drive_hi` is 0 after that edge. `drive_lo` becomes 1 D clocks later.
- R4: `drive_hi` and `drive_lo` are never 1 in the same cycle.
- R5: With `dead_cycles` = 0 in pair mode, the drives swap at the edge that samples the new raw level, with no cycle where both are 0.
- R6: The gap is counted in system clocks and subtracted from the active time. A raw level held for H clocks with H > D gives H − D clocks of the matching drive, so the period is kept.
- R7: If `pwm_raw` flips back during a gap, the pending drive never asserts. A fresh gap of D clocks starts toward the other side.
- R8: A change of `dead_cycles` during a running gap does not alter that gap. The new value applies from the next gap start.
- R9: With `pair_en` = 0, after each edge `drive_hi` equals the sampled `pwm_raw` and `drive_lo` its inverse, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the gap is counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_raw | input | 1 | Raw modulator level, 1 = high side should conduct |
| pair_en | input | 1 | 1 = complementary pair with gap, 0 = plain tracking |
| dead_cycles | input | 8 | Gap length in system clocks, 0 to 255 |
| drive_hi | output | 1 | High-side drive, 1 = on |
| drive_lo | output | 1 | Low-side drive, 1 = on |

## Verification
The drives are a direct decode of the state register, so a wrong state shows at the ports within the same cycle. It appears as a drive that is on against the sampled raw level, as both drives on together, or as a drive that is off when it should be on. A counter that is loaded or decremented wrongly changes where the turn-on edge falls, by exactly the miscount. This is checked for gaps of 0, 1, 2, 3, 4, 5 and 255 clocks, and for gaps that are interrupted or retimed.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    localparam int DEAD_W = 8;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_LO_ON  = 3'd1,
        ST_GAP_HI = 3'd2,
        ST_HI_ON  = 3'd3,
        ST_GAP_LO = 3'd4
    } drv_state_e;

endpackage

// File: rtl/cpwm_gap_counter.sv
module cpwm_gap_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic         last
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    // Loaded at gap start, so a later change of the gap input cannot move it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (step && (cnt_q != '0)) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign last = (cnt_q == ONE);

endmodule

// File: rtl/cpwm_drive_fsm.sv
module cpwm_drive_fsm
    import cpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         raw,
    input  logic         pair,
    input  logic [W-1:0] gap_len,
    input  logic         gap_last,
    output logic         gap_load,
    output logic         gap_step,
    output logic         hi_on,
    output logic         lo_on
);
    drv_state_e cur_q, nxt;
    logic       zero_gap;

    assign zero_gap = (gap_len == '0);

    // Next-state and counter control.
    always_comb begin
        nxt      = cur_q;
        gap_load = 1'b0;
        gap_step = 1'b0;
        if (!pair) begin
            nxt = raw ? ST_HI_ON : ST_LO_ON;
        end else begin
            unique case (cur_q)
                ST_OFF: begin
                    if (raw) begin
                        nxt      = zero_gap ? ST_HI_ON : ST_GAP_HI;
                        gap_load = !zero_gap;
                    end else begin
                        nxt      = zero_gap ? ST_LO_ON : ST_GAP_LO;
                        gap_load = !zero_gap;
                    end
                end
                ST_LO_ON: begin
                    if (raw) begin
                        nxt      = zero_gap ? ST_HI_ON : ST_GAP_HI;
                        gap_load = !zero_gap;
                    end
                end
                ST_HI_ON: begin
                    if (!raw) begin
                        nxt      = zero_gap ? ST_LO_ON : ST_GAP_LO;
                        gap_load = !zero_gap;
                    end
                end
                ST_GAP_HI: begin
                    if (!raw) begin
                        nxt      = zero_gap ? ST_LO_ON : ST_GAP_LO;
                        gap_load = !zero_gap;
                    end else if (gap_last) begin
                        nxt = ST_HI_ON;
                    end else begin
                        gap_step = 1'b1;
                    end
                end
                ST_GAP_LO: begin
                    if (raw) begin
                        nxt      = zero_gap ? ST_HI_ON : ST_GAP_HI;
                        gap_load = !zero_gap;
                    end else if (gap_last) begin
                        nxt = ST_LO_ON;
                    end else begin
                        gap_step = 1'b1;
                    end
                end
                default: begin
                    nxt = ST_OFF;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= ST_OFF;
        end else begin
            cur_q <= nxt;
        end
    end

    // Output decode: a drive is on only in its own on state.
    always_comb begin
        hi_on = 1'b0;
        lo_on = 1'b0;
        unique case (cur_q)
            ST_HI_ON: hi_on = 1'b1;
            ST_LO_ON: lo_on = 1'b1;
            default: begin
                hi_on = 1'b0;
                lo_on = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime
    import cpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwm_raw,
    input  logic              pair_en,
    input  logic [DEAD_W-1:0] dead_cycles,
    output logic              drive_hi,
    output logic              drive_lo
);
    logic gap_load, gap_step, gap_last;

    cpwm_drive_fsm #(.W(DEAD_W)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw      (pwm_raw),
        .pair     (pair_en),
        .gap_len  (dead_cycles),
        .gap_last (gap_last),
        .gap_load (gap_load),
        .gap_step (gap_step),
        .hi_on    (drive_hi),
        .lo_on    (drive_lo)
    );

    cpwm_gap_counter #(.W(DEAD_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (dead_cycles),
        .step     (gap_step),
        .last     (gap_last)
    );

endmodule

// File: rtl/cpwm_deadtime_chk.sv
module cpwm_deadtime_chk (
    input logic clk,
    input logic rst_n,
    input logic pwm_raw,
    input logic pair_en,
    input logic drive_hi,
    input logic drive_lo
);
    logic run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    // R1: drives are low whenever reset is applied
    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_low_R1: assert (!drive_hi && !drive_lo);
        end
    end

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_hi && drive_lo));

    assert_hi_off_at_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !$past(pwm_raw)) |-> !drive_hi);

    assert_lo_off_at_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(pwm_raw)) |-> !drive_lo);

    assert_hi_on_needs_raw_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $rose(drive_hi)) |-> $past(pwm_raw));

    assert_lo_on_needs_raw_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $rose(drive_lo)) |-> !$past(pwm_raw));

    assert_bypass_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !$past(pair_en)) |->
            (drive_hi == $past(pwm_raw)) && (drive_lo == !$past(pwm_raw)));

endmodule

bind cpwm_deadtime cpwm_deadtime_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_raw  (pwm_raw),
    .pair_en  (pair_en),
    .drive_hi (drive_hi),
    .drive_lo (drive_lo)
);

// File: tb/test_cpwm_deadtime.sv
`timescale 1ns/1ps
module test_cpwm_deadtime;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pwm_raw;
    logic       pair_en;
    logic [7:0] dead_cycles;
    logic       drive_hi, drive_lo;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    cpwm_deadtime i_cpwm_deadtime (
        .clk(clk), .rst_n(rst_n), .pwm_raw(pwm_raw), .pair_en(pair_en),
        .dead_cycles(dead_cycles), .drive_hi(drive_hi), .drive_lo(drive_lo)
    );

    // Vector: {req[3:0], pair, raw, dead[7:0], exp_hi, exp_lo}; expectation after next edge
    localparam int NV = 33;
    localparam logic [15:0] VEC [0:NV-1] = '{
        {4'd1, 1'b1, 1'b0, 8'd3, 2'b00},  // R1 gap toward low after release
        {4'd1, 1'b1, 1'b0, 8'd3, 2'b00},
        {4'd1, 1'b1, 1'b0, 8'd3, 2'b00},
        {4'd1, 1'b1, 1'b0, 8'd3, 2'b01},
        {4'd1, 1'b1, 1'b0, 8'd3, 2'b01},
        {4'd2, 1'b1, 1'b1, 8'd3, 2'b00},  // R2 rise: low off at once
        {4'd2, 1'b1, 1'b1, 8'd3, 2'b00},
        {4'd2, 1'b1, 1'b1, 8'd3, 2'b00},
        {4'd2, 1'b1, 1'b1, 8'd3, 2'b10},  // R2 high on after 3 clocks
        {4'd2, 1'b1, 1'b1, 8'd3, 2'b10},
        {4'd3, 1'b1, 1'b0, 8'd3, 2'b00},  // R3 fall: high off at once
        {4'd7, 1'b1, 1'b1, 8'd3, 2'b00},  // R7 flip back, restart
        {4'd7, 1'b1, 1'b1, 8'd3, 2'b00},
        {4'd7, 1'b1, 1'b1, 8'd3, 2'b00},
        {4'd7, 1'b1, 1'b1, 8'd3, 2'b10},
        {4'd5, 1'b1, 1'b0, 8'd0, 2'b01},  // R5 zero gap swap
        {4'd5, 1'b1, 1'b1, 8'd0, 2'b10},
        {4'd5, 1'b1, 1'b0, 8'd0, 2'b01},
        {4'd8, 1'b1, 1'b1, 8'd2, 2'b00},  // R8 gap of 2 captured
        {4'd8, 1'b1, 1'b1, 8'd5, 2'b00},  // R8 change mid-gap ignored
        {4'd8, 1'b1, 1'b1, 8'd5, 2'b10},
        {4'd3, 1'b1, 1'b0, 8'd5, 2'b00},  // R3 new value used at next start
        {4'd3, 1'b1, 1'b0, 8'd5, 2'b00},
        {4'd3, 1'b1, 1'b0, 8'd5, 2'b00},
        {4'd3, 1'b1, 1'b0, 8'd5, 2'b00},
        {4'd3, 1'b1, 1'b0, 8'd5, 2'b00},
        {4'd3, 1'b1, 1'b0, 8'd5, 2'b01},
        {4'd9, 1'b0, 1'b1, 8'd5, 2'b10},  // R9 bypass tracking
        {4'd9, 1'b0, 1'b0, 8'd5, 2'b01},
        {4'd9, 1'b0, 1'b1, 8'd5, 2'b10},
        {4'd9, 1'b0, 1'b1, 8'd5, 2'b10},
        {4'd3, 1'b1, 1'b0, 8'd1, 2'b00},  // R3 gap of 1
        {4'd3, 1'b1, 1'b0, 8'd1, 2'b01}
    };

    task automatic check(input string req, input int act, input int exp, input string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int hi_cnt, lo_cnt, both_cnt, first_hi;
        rst_n = 1'b0; pwm_raw = 1'b0; pair_en = 1'b1; dead_cycles = 8'd3;
        repeat (3) @(negedge clk);
        check("R1", {drive_hi, drive_lo}, 0, "drives in reset");
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            pair_en     = VEC[i][11];
            pwm_raw     = VEC[i][10];
            dead_cycles = VEC[i][9:2];
            @(negedge clk);
            check($sformatf("R%0d", VEC[i][15:12]), {drive_hi, drive_lo},
                  VEC[i][1:0], $sformatf("vector %0d {hi,lo}", i));
        end

        // R6: active time shortened by the gap, period kept (state is low-on here)
        dead_cycles = 8'd4;
        hi_cnt = 0; lo_cnt = 0; both_cnt = 0;
        pwm_raw = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            hi_cnt += drive_hi;
            both_cnt += (drive_hi && drive_lo);
        end
        pwm_raw = 1'b0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            lo_cnt += drive_lo;
            both_cnt += (drive_hi && drive_lo);
        end
        check("R6", hi_cnt, 6, "high-side on cycles in 10-cycle high");
        check("R6", lo_cnt, 6, "low-side on cycles in 10-cycle low");

        // Maximum gap of 255 clocks (R2 boundary)
        dead_cycles = 8'd255;
        pwm_raw = 1'b1;
        first_hi = 0;
        for (int k = 1; k <= 300; k++) begin
            @(negedge clk);
            if (k == 1) check("R2", drive_lo, 0, "low-side off right after edge, gap 255");
            both_cnt += (drive_hi && drive_lo);
            if (drive_hi && first_hi == 0) first_hi = k;
        end
        check("R2", first_hi, 256, "sample where high-side turns on, gap 255");
        check("R4", both_cnt, 0, "cycles with both drives on");

        // R1: reset mid-run clears outputs and counter
        @(posedge clk);
        #1 rst_n = 1'b0;
        #1 check("R1", {drive_hi, drive_lo}, 0, "drives right after async reset");
        @(negedge clk);
        dead_cycles = 8'd2;
        pwm_raw = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {drive_hi, drive_lo}, 0, "first gap cycle after reset");
        @(negedge clk);
        check("R1", {drive_hi, drive_lo}, 0, "second gap cycle after reset");
        @(negedge clk);
        check("R1", {drive_hi, drive_lo}, 2, "high-side on after 2-cycle gap");

        summary();
    end

endmodule